// File: doc/BRIEF.md
# Proportional Patch and Level Combiner

This block turns control channel levels into dimmer output levels for a stage lighting controller. A frame begins when the `start` strobe is seen while the block is idle. In the first phase, the block visits every control channel. For each channel it takes the cue level and the level recorded in each submaster group. Each submaster level is first scaled by that group's fader. The block keeps the highest of these values, so the brightest contribution wins, and stores the result in an internal buffer that holds one byte per channel.

In the second phase, the block walks through the patch memory one dimmer at a time. Each dimmer reads its patched channel from the buffer, scales that level by the dimmer's own proportion, and writes the result into an external dimmer level RAM. A separate serial output stage reads that RAM.

Every scaling step is an 8-bit by 8-bit product, reduced to one byte. The block reads its external memories asynchronously: an address goes out and the data comes back in the same cycle. With the default sizes, a full frame takes 29,096 cycles. That fits easily within a 30 ms refresh period at any ordinary clock rate.

Top module: `dimmer_patch_engine`

## Requirements
- R1: Every scaling step of a level `a` by a factor `b` (both 8-bit unsigned) gives the upper byte of `a*b + 255`. So 255 scaled by 255 is 255, 0 scaled by anything is 0, and 1 scaled by 1 is 1.
- R2: A patch word is laid out as {valid in bit CW+8, channel in bits CW+7:8, proportion in bits 7:0}. For a valid entry, the dimmer level written is the merged level of that channel scaled by the proportion (R1). Any number of dimmers may name the same channel.
- R3: The merged level of a channel is the maximum of two kinds of value. The first is the cue level, read with `src_sel` = 0. The others are the submaster levels, read with `src_sel` = k for k = 1..NSUB, each scaled by fader byte `faders[8k-1:8(k-1)]`. The values are never summed.
- R4: A dimmer whose patch entry has the valid bit clear, or whose channel is NCH or above, is written with level 0.
- R5: A `start` seen while idle begins a frame. `busy` then stays high for exactly NCH*(NSUB+1)+NDIM cycles.
- R6: `done` is high for exactly one cycle: the first cycle in which `busy` is low again after a frame.
- R7: `start` has no effect while `busy` is high, including in the last cycle of a frame. No second frame follows.
- R8: In each frame, every dimmer address 0..NDIM-1 is written exactly once, in ascending order. `dim_we` is never high outside a frame.
- R9: While reset is held and after it is released, `busy`, `done` and `dim_we` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Frame start strobe |
| busy | output | 1 | Frame in progress |
| done | output | 1 | One-cycle end-of-frame pulse |
| src_sel | output | $clog2(NSUB+1) | Level source: 0 = cue, k = submaster k |
| src_ch | output | $clog2(NCH) | Channel being read from the level source |
| src_level | input | 8 | Level returned for src_sel/src_ch, same cycle |
| faders | input | NSUB*8 | Fader byte of each submaster, group k in byte k-1 |
| patch_addr | output | $clog2(NDIM) | Dimmer index being read from the patch RAM |
| patch_data | input | $clog2(NCH)+9 | Patch word {valid, channel, proportion}, same cycle |
| dim_we | output | 1 | Dimmer RAM write enable |
| dim_addr | output | $clog2(NDIM) | Dimmer RAM write address |
| dim_level | output | 8 | Dimmer RAM write data |

## Verification
A corrupted entry in the merged channel buffer shows up only in the patch phase, as a wrong level on every dimmer patched to that channel. So a full frame must complete before the fault can be seen. A wrong channel or submaster counter shows as a frame length that differs from NCH*(NSUB+1)+NDIM, or as a mismatch against a maximum computed in the bench, again at the end of the frame. A wrong dimmer counter shows at once, as an out-of-order or missing `dim_addr` write. The sweeps vary cue levels and proportions across 256 frames, so every byte value appears at both inputs of the scaler.

// File: rtl/dimmer_patch_engine.sv
module dimmer_patch_engine #(
  parameter int NCH  = 1000,
  parameter int NSUB = 24,
  parameter int NDIM = 4096,
  localparam int CW  = $clog2(NCH),
  localparam int SW  = $clog2(NSUB + 1),
  localparam int DW  = $clog2(NDIM),
  localparam int PW  = CW + 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  output logic              busy,
  output logic              done,
  output logic [SW-1:0]     src_sel,
  output logic [CW-1:0]     src_ch,
  input  logic [7:0]        src_level,
  input  logic [NSUB*8-1:0] faders,
  output logic [DW-1:0]     patch_addr,
  input  logic [PW-1:0]     patch_data,
  output logic              dim_we,
  output logic [DW-1:0]     dim_addr,
  output logic [7:0]        dim_level
);

  typedef enum logic [1:0] {S_IDLE, S_MERGE, S_PATCH} state_t;

  function automatic logic [7:0] scale8(input logic [7:0] a, input logic [7:0] b);
    logic [15:0] p;
    p = 16'(a) * 16'(b) + 16'd255;
    return p[15:8];
  endfunction

  state_t      st;
  logic [CW-1:0] ch_r;
  logic [SW-1:0] src_r;
  logic [7:0]    acc_r;
  logic [DW-1:0] d_r;
  logic          done_r;
  logic [7:0]    merged [NCH];

  logic [7:0] fad [NSUB];
  for (genvar g = 0; g < NSUB; g++) begin : g_fad
    assign fad[g] = faders[8*g +: 8];
  end

  logic [SW-1:0] fidx;
  logic [7:0]    contrib, acc_nx;
  assign fidx    = (src_r == '0) ? '0 : src_r - 1'b1;
  assign contrib = (src_r == '0) ? src_level : scale8(src_level, fad[fidx]);
  assign acc_nx  = (src_r == '0 || contrib > acc_r) ? contrib : acc_r;

  logic          p_valid, p_hit;
  logic [CW-1:0] p_chan;
  logic [7:0]    p_prop;
  assign p_valid = patch_data[PW-1];
  assign p_chan  = patch_data[CW+7:8];
  assign p_prop  = patch_data[7:0];
  assign p_hit   = p_valid && ({1'b0, p_chan} < (CW+1)'(NCH));

  assign src_sel    = src_r;
  assign src_ch     = ch_r;
  assign patch_addr = d_r;
  assign busy       = (st != S_IDLE);
  assign done       = done_r;
  assign dim_we     = (st == S_PATCH);
  assign dim_addr   = d_r;
  assign dim_level  = p_hit ? scale8(merged[p_chan], p_prop) : 8'd0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      ch_r   <= '0;
      src_r  <= '0;
      acc_r  <= '0;
      d_r    <= '0;
      done_r <= 1'b0;
    end else begin
      done_r <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          st    <= S_MERGE;
          ch_r  <= '0;
          src_r <= '0;
        end
        S_MERGE: begin
          acc_r <= acc_nx;
          if (src_r == SW'(NSUB)) begin
            src_r <= '0;
            if (ch_r == CW'(NCH - 1)) begin
              st  <= S_PATCH;
              d_r <= '0;
            end else begin
              ch_r <= ch_r + 1'b1;
            end
          end else begin
            src_r <= src_r + 1'b1;
          end
        end
        S_PATCH: begin
          if (d_r == DW'(NDIM - 1)) begin
            st     <= S_IDLE;
            done_r <= 1'b1;
          end else begin
            d_r <= d_r + 1'b1;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (st == S_MERGE && src_r == SW'(NSUB))
      merged[ch_r] <= acc_nx;
  end

endmodule

// File: rtl/dimmer_patch_engine_chk.sv
module dimmer_patch_engine_chk #(
  parameter int NCH  = 1000,
  parameter int NSUB = 24,
  parameter int NDIM = 4096,
  localparam int CW  = $clog2(NCH),
  localparam int DW  = $clog2(NDIM),
  localparam int PW  = CW + 9,
  localparam int FRAME = NCH * (NSUB + 1) + NDIM
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic          busy,
  input logic          done,
  input logic [PW-1:0] patch_data,
  input logic          dim_we,
  input logic [DW-1:0] dim_addr,
  input logic [7:0]    dim_level
);

  int unsigned busy_cnt;
  int unsigned wr_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_cnt <= 0;
      wr_cnt   <= 0;
    end else begin
      busy_cnt <= busy ? busy_cnt + 1 : 0;
      if (dim_we) wr_cnt <= wr_cnt + 1;
      else if (!busy) wr_cnt <= 0;
    end
  end

  always_comb begin
    if (!rst_n) begin
      a_reset_quiet_r9: assert (!dim_we);
    end
  end

  p_we_in_frame_r8: assert property (@(posedge clk) disable iff (!rst_n)
    dim_we |-> busy);

  p_addr_order_r8: assert property (@(posedge clk) disable iff (!rst_n)
    dim_we |-> (32'(dim_addr) == wr_cnt));

  p_frame_len_r5: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (busy_cnt == FRAME));

  p_done_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_done_on_fall_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);

  p_unpatched_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (dim_we && !patch_data[PW-1]) |-> (dim_level == 8'd0));

  p_level_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    dim_we |-> (dim_level <= patch_data[7:0]));

  p_start_ignored_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !dim_we && start) |=> busy);

endmodule

bind dimmer_patch_engine dimmer_patch_engine_chk #(
  .NCH(NCH), .NSUB(NSUB), .NDIM(NDIM)
) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
  .patch_data(patch_data), .dim_we(dim_we), .dim_addr(dim_addr),
  .dim_level(dim_level)
);

// File: tb/tb_dimmer_patch_engine.sv
module tb_dimmer_patch_engine;
  localparam int NCH = 6, NSUB = 2, NDIM = 12;
  localparam int CW = $clog2(NCH), SW = $clog2(NSUB + 1), DW = $clog2(NDIM), PW = CW + 9;
  localparam int FRAME = NCH * (NSUB + 1) + NDIM;

  logic clk = 0, rst_n = 0, start = 0;
  logic busy, done, dim_we;
  logic [SW-1:0] src_sel;
  logic [CW-1:0] src_ch;
  logic [7:0] src_level, dim_level;
  logic [NSUB*8-1:0] faders;
  logic [DW-1:0] patch_addr, dim_addr;
  logic [PW-1:0] patch_data;

  int cue [NCH];
  int subm [NSUB][NCH];
  int fad [NSUB];
  logic [PW-1:0] ptab [NDIM];
  int checks = 0, failures = 0;

  always #2.5 clk = ~clk;

  dimmer_patch_engine #(.NCH(NCH), .NSUB(NSUB), .NDIM(NDIM)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
    .src_sel(src_sel), .src_ch(src_ch), .src_level(src_level), .faders(faders),
    .patch_addr(patch_addr), .patch_data(patch_data), .dim_we(dim_we),
    .dim_addr(dim_addr), .dim_level(dim_level));

  always_comb begin
    if (src_sel == 0) src_level = 8'(cue[src_ch]);
    else src_level = 8'(subm[src_sel - 1][src_ch]);
    for (int s = 0; s < NSUB; s++) faders[8*s +: 8] = 8'(fad[s]);
    patch_data = ptab[patch_addr];
  end

  function automatic int sc(int a, int b);
    return (a * b + 255) / 256;
  endfunction

  function automatic int exp_dim(int d);
    int ch, m, v;
    if (ptab[d][PW-1] == 1'b0) return 0;
    ch = int'(ptab[d][CW+7:8]);
    if (ch >= NCH) return 0;
    m = cue[ch];
    for (int s = 0; s < NSUB; s++) begin
      v = sc(subm[s][ch], fad[s]);
      if (v > m) m = v;
    end
    return sc(m, int'(ptab[d][7:0]));
  endfunction

  task automatic chk(bit ok, string req, int act, int expv);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  function automatic logic [PW-1:0] pw(int v, int ch, int p);
    return {v[0], CW'(ch), 8'(p)};
  endfunction

  task automatic run_frame(string tag, int extra_at);
    int len = 0, wr = 0, order_ok = 1;
    int got [NDIM];
    @(negedge clk) start = 1;
    @(negedge clk) start = 0;
    while (busy) begin
      start = (len == extra_at);
      if (dim_we) begin
        if (int'(dim_addr) != wr || wr >= NDIM) order_ok = 0;
        else got[wr] = int'(dim_level);
        wr++;
      end
      len++;
      @(negedge clk);
    end
    start = 0;
    chk(done == 1'b1, "R6 done at end", int'(done), 1);
    chk(len == FRAME, "R5 frame length", len, FRAME);
    chk(order_ok == 1 && wr == NDIM, "R8 write order/count", wr, NDIM);
    for (int d = 0; d < NDIM && d < wr; d++)
      chk(got[d] == exp_dim(d), tag, got[d], exp_dim(d));
    @(negedge clk);
    chk(done == 1'b0, "R6 done single pulse", int'(done), 0);
    chk(busy == 1'b0, "R7 no second frame", int'(busy), 0);
  endtask

  initial begin
    #(5 * 150000);
    failures++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    for (int c = 0; c < NCH; c++) begin
      cue[c] = 0;
      for (int s = 0; s < NSUB; s++) subm[s][c] = 0;
    end
    for (int s = 0; s < NSUB; s++) fad[s] = 0;
    for (int d = 0; d < NDIM; d++) ptab[d] = '0;
    repeat (3) @(negedge clk);
    chk(busy == 0 && done == 0 && dim_we == 0, "R9 reset quiet", int'({busy, done, dim_we}), 0);
    rst_n = 1;
    repeat (2) @(negedge clk);
    chk(busy == 0 && done == 0 && dim_we == 0, "R9 after reset", int'({busy, done, dim_we}), 0);

    // R1/R2 sweep: faders zero, cue levels and proportions cover all bytes
    for (int k = 0; k < 256; k++) begin
      for (int c = 0; c < NCH; c++) begin
        cue[c] = (k + 37 * c) & 255;
        for (int s = 0; s < NSUB; s++) subm[s][c] = (k * 5 + c) & 255;
      end
      for (int d = 0; d < NDIM; d++)
        ptab[d] = pw(1, d % NCH, (d == 0) ? 255 : ((d * 23 + k * 7) & 255));
      run_frame("R1 R2 scaled level", -1);
    end

    // R3: submasters merged by maximum
    for (int k = 0; k < 6; k++) begin
      fad[0] = (k == 0) ? 255 : (k * 51) & 255;
      fad[1] = (k == 5) ? 0 : 255 - k * 40;
      for (int c = 0; c < NCH; c++) begin
        cue[c] = (c * 30 + k * 11) & 255;
        subm[0][c] = (255 - c * 40 + k) & 255;
        subm[1][c] = (c * 50 + k * 17) & 255;
      end
      for (int d = 0; d < NDIM; d++) ptab[d] = pw(1, d % NCH, 255 - d * 3);
      run_frame("R3 max merge", -1);
    end

    // R2: many dimmers share one channel
    fad[0] = 200; fad[1] = 17;
    for (int d = 0; d < NDIM; d++) ptab[d] = pw(1, 2, d * 21);
    run_frame("R2 shared channel", -1);

    // R4: unpatched and out-of-range channels give zero
    for (int c = 0; c < NCH; c++) cue[c] = 255;
    for (int d = 0; d < NDIM; d++)
      ptab[d] = (d % 3 == 0) ? pw(0, d % NCH, 255) :
                (d % 3 == 1) ? pw(1, 6 + (d & 1), 255) : pw(1, d % NCH, 200);
    run_frame("R4 unpatched zero", -1);

    // R7: start during a frame, mid-frame and on the last busy cycle
    for (int d = 0; d < NDIM; d++) ptab[d] = pw(1, d % NCH, 128 + d);
    run_frame("R7 start mid-frame", 3);
    run_frame("R7 start last cycle", FRAME - 1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule